// File: doc/BRIEF.md
# Pin Bank With Input Inversion, Blinking and Interrupts

This block controls a bank of general-purpose pins through a small word-wide register interface. Each pin is set as a driven output or an observed input. Outputs drive a stored value. A pin can instead flip in step with a shared blink clock. The blink clock comes from a programmable divider of the system clock.

Inputs pass through a two-stage synchronizer. A per-pin inversion bit is then applied, so an active-low signal reads as logic 1 when asserted. The corrected level serves two purposes: it is read back, and it feeds interrupt detection.

Rising edges of the corrected level are caught in a sticky pending register. Software acknowledges a pending bit by writing 0 to it. Pending edges and corrected levels are each filtered by their own mask, and the results are merged into a single interrupt line.

Top module: `gpio_bank`

## Requirements
- R1: Register index 1 holds the direction. A bit value of 0 makes the pin an output (`pin_oe` bit high) and 1 makes it an input. The new value takes effect in the cycle after the write.
- R2: Reading index 4 returns, for every pin (outputs included), the pin level sampled by two clock edges XOR the inversion register (index 3). A change on `pin_in` shows up after the second rising edge.
- R3: `pin_out` equals the output register (index 0). The exception is a pin that is an output and has its blink bit (index 2) set: that pin drives the output-register value XOR the shared blink phase.
- R4: A 0-to-1 transition of the corrected level sets that pin's bit in the pending register (index 5) on the third rising edge after the pin change. The bit then stays set until software clears it.
- R5: Writing index 5 clears the pending bits written as 0 and leaves the bits written as 1 unchanged. An edge detected in the same cycle as the clear wins, and its bit stays set.
- R6: `irq` is high when any pin has a pending bit and its edge-mask bit (index 6) set, or a corrected level of 1 and its level-mask bit (index 7) set. A pin with both mask bits 0 never raises `irq`.
- R7: Index 8 holds the blink period P, zero-extended on read. The blink phase starts at 0 after reset and toggles once every P+1 cycles. A write to index 8 restarts the count without a toggle in that cycle.
- R8: Indices 0, 1, 2, 3, 6 and 7 read back the last value written. A write to index 4 has no effect. Unused indices read as 0. Reads are combinational on `bus_addr`.
- R9: Synchronous active-low reset sets the direction register to all ones (all pins inputs, `pin_oe` all 0). It clears every other register, the blink phase and the pending bits, so `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Output levels toward the pads |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
Results fall due at different points after a stimulus:
- A register write appears on the read port and on `pin_oe`/`pin_out` one edge later.
- The corrected input level and any level interrupt appear two edges after a pin change.
- A pending bit and any edge interrupt appear on the third edge.
- The blink phase moves every P+1 edges after the last period write.

The bench steps a behavioural model on the same rising edge that updates the design. It compares every output at the following falling edge, so each result is checked in the first cycle in which it is due and in every later cycle. Directed sequences aim a clear write at the exact cycle in which a new edge is latched. Random traffic covers the remaining orderings.

// File: rtl/gpio_pkg.sv
// Shared constants for the pin bank: register index map and bus address width.
// Assumes a single flat index space decoded by gpio_regfile.
package gpio_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] IDX_OUT    = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_DIR    = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_BLINK  = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_INV    = 4'd3;
    localparam logic [ADDR_W-1:0] IDX_LEVEL  = 4'd4;
    localparam logic [ADDR_W-1:0] IDX_PEND   = 4'd5;
    localparam logic [ADDR_W-1:0] IDX_EMASK  = 4'd6;
    localparam logic [ADDR_W-1:0] IDX_LMASK  = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_PERIOD = 4'd8;
endpackage

// File: rtl/gpio_sync_edge.sv
// Input path: two-stage synchronizer, per-pin inversion, rising-edge detect.
// Assumes pin_in is asynchronous to clk; inv may change at any cycle, and a
// change that lifts the corrected level counts as a rising edge.
module gpio_sync_edge #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic [NPIN-1:0] inv,
    output logic [NPIN-1:0] level,
    output logic [NPIN-1:0] rise
);
    logic [NPIN-1:0] meta_q;
    logic [NPIN-1:0] sync_q;
    logic [NPIN-1:0] last_q;

    // Two flops bring the raw pins into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
        end
    end

    // Inversion applied once, shared by readback and interrupt logic.
    assign level = sync_q ^ inv;

    // Remember last corrected level for the edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= level;
    end

    // Edge pulse per pin: corrected level was 0, is now 1.
    assign rise = level & ~last_q;

    // R2
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gpio_blink_div.sv
// Blink phase generator: a counter wraps every PERIOD+1 cycles and flips a
// shared phase bit. A restart pulse (period write) zeroes the counter.
module gpio_blink_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] period,
    input  logic             restart,
    output logic             phase
);
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;

    // Count up to the period, wrap and toggle the phase on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (restart) begin
            cnt_q   <= '0;
        end else if (cnt_q == period) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;

    // R7
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> ($past(cnt_q) == $past(period) && !$past(restart)));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/gpio_regfile.sv
// Register file: configuration registers, sticky pending register, blink
// period and the combinational read mux. Assumes one write per cycle.
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    input  logic [NPIN-1:0]   level,
    input  logic [NPIN-1:0]   rise,
    output logic [NPIN-1:0]   out_q,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   blink_q,
    output logic [NPIN-1:0]   inv_q,
    output logic [NPIN-1:0]   emask_q,
    output logic [NPIN-1:0]   lmask_q,
    output logic [NPIN-1:0]   pend_q,
    output logic [DIV_W-1:0]  period_q,
    output logic              period_wr,
    output logic [NPIN-1:0]   bus_rdata
);
    localparam int PAD_W = NPIN - DIV_W;

    logic            wr_pend;
    logic [NPIN-1:0] pend_keep;
    logic [NPIN-1:0] pend_nxt;

    assign wr_pend   = bus_wr && (bus_addr == IDX_PEND);
    assign period_wr = bus_wr && (bus_addr == IDX_PERIOD);

    // Plain configuration registers, loaded on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= '0;
            dir_q    <= '1;
            blink_q  <= '0;
            inv_q    <= '0;
            emask_q  <= '0;
            lmask_q  <= '0;
            period_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                IDX_OUT:    out_q    <= bus_wdata;
                IDX_DIR:    dir_q    <= bus_wdata;
                IDX_BLINK:  blink_q  <= bus_wdata;
                IDX_INV:    inv_q    <= bus_wdata;
                IDX_EMASK:  emask_q  <= bus_wdata;
                IDX_LMASK:  lmask_q  <= bus_wdata;
                IDX_PERIOD: period_q <= bus_wdata[DIV_W-1:0];
                default:    ;
            endcase
        end
    end

    // Pending update: write-0-to-clear, new edges override the clear.
    always_comb begin
        pend_keep = wr_pend ? bus_wdata : '1;
        pend_nxt  = (pend_q & pend_keep) | rise;
    end

    // Sticky pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    // Combinational read mux over the index space.
    always_comb begin
        case (bus_addr)
            IDX_OUT:    bus_rdata = out_q;
            IDX_DIR:    bus_rdata = dir_q;
            IDX_BLINK:  bus_rdata = blink_q;
            IDX_INV:    bus_rdata = inv_q;
            IDX_LEVEL:  bus_rdata = level;
            IDX_PEND:   bus_rdata = pend_q;
            IDX_EMASK:  bus_rdata = emask_q;
            IDX_LMASK:  bus_rdata = lmask_q;
            IDX_PERIOD: bus_rdata = {{PAD_W{1'b0}}, period_q};
            default:    bus_rdata = '0;
        endcase
    end

    // R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R4
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pend |=> (($past(pend_q) & ~pend_q) == '0));

    // R5
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & ~$past(bus_wdata) & ~$past(rise)) == '0));
endmodule

// File: rtl/gpio_bank.sv
// Top of the pin bank: ties the input path, blink divider and register file
// together, forms pad outputs and the merged interrupt. Pads and pin muxing
// are outside this block.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [NPIN-1:0]  level;
    logic [NPIN-1:0]  rise;
    logic [NPIN-1:0]  out_q, dir_q, blink_q, inv_q, emask_q, lmask_q, pend_q;
    logic [DIV_W-1:0] period_q;
    logic             period_wr;
    logic             phase;
    logic [NPIN-1:0]  flip;

    gpio_sync_edge #(.NPIN(NPIN)) u_in (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .inv    (inv_q),
        .level  (level),
        .rise   (rise)
    );

    gpio_blink_div #(.DIV_W(DIV_W)) u_blink (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period_q),
        .restart (period_wr),
        .phase   (phase)
    );

    gpio_regfile #(.NPIN(NPIN), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .level     (level),
        .rise      (rise),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .blink_q   (blink_q),
        .inv_q     (inv_q),
        .emask_q   (emask_q),
        .lmask_q   (lmask_q),
        .pend_q    (pend_q),
        .period_q  (period_q),
        .period_wr (period_wr),
        .bus_rdata (bus_rdata)
    );

    // Pad side: drive enable is the inverse of the input-select bit.
    assign pin_oe = ~dir_q;

    // Blinking output pins follow the shared phase.
    assign flip    = blink_q & ~dir_q & {NPIN{phase}};
    assign pin_out = out_q ^ flip;

    // One interrupt from masked pending edges and masked levels.
    assign irq = |((pend_q & emask_q) | (level & lmask_q));

    // R1
    dir_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R6
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> !irq);

    // R3
    hold_when_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_q == '0 && $past(blink_q) == '0 && $stable(out_q)) |-> $stable(pin_out));
endmodule

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_out, m_dir, m_blk, m_inv, m_em, m_lm, m_pend;
    logic [31:0] m_hist1, m_hist2, m_lastlvl;
    logic [15:0] m_per;
    int          m_cnt;
    bit          m_ph;

    always @(posedge clk) begin : model
        logic [31:0] lvl, up, keep;
        if (!rst_n) begin
            m_out = 0; m_dir = '1; m_blk = 0; m_inv = 0; m_em = 0; m_lm = 0;
            m_pend = 0; m_hist1 = 0; m_hist2 = 0; m_lastlvl = 0;
            m_per = 0; m_cnt = 0; m_ph = 0;
        end else begin
            lvl  = m_hist2 ^ m_inv;
            up   = lvl & ~m_lastlvl;
            keep = (bus_wr && bus_addr == 4'd5) ? bus_wdata : 32'hFFFF_FFFF;
            m_pend    = (m_pend & keep) | up;
            m_lastlvl = lvl;
            m_hist2   = m_hist1;
            m_hist1   = pin_in;
            if (bus_wr && bus_addr == 4'd8) begin
                m_per = bus_wdata[15:0];
                m_cnt = 0;
            end else if (m_cnt == int'(m_per)) begin
                m_cnt = 0;
                m_ph  = ~m_ph;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: m_out = bus_wdata;
                    4'd1: m_dir = bus_wdata;
                    4'd2: m_blk = bus_wdata;
                    4'd3: m_inv = bus_wdata;
                    4'd6: m_em  = bus_wdata;
                    4'd7: m_lm  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            4'd0: return m_out;
            4'd1: return m_dir;
            4'd2: return m_blk;
            4'd3: return m_inv;
            4'd4: return m_hist2 ^ m_inv;
            4'd5: return m_pend;
            4'd6: return m_em;
            4'd7: return m_lm;
            4'd8: return {16'h0, m_per};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [3:0] a);
        case (a)
            4'd4: return "R2";
            4'd5: return "R4 R5";
            4'd8: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pin_oe, ~m_dir, "R1", "pin_oe");
            chk(pin_out, m_out ^ (m_blk & ~m_dir & {32{m_ph}}), "R3 R7", "pin_out");
            chk({31'b0, irq}, {31'b0, |((m_pend & m_em) | ((m_hist2 ^ m_inv) & m_lm))}, "R6", "irq");
            chk(bus_rdata, exp_rd(bus_addr), rd_tag(bus_addr), "rdata");
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 1'b0;
    endtask

    initial begin
        step(3);
        // R9: reset values observed while reset is held
        bus_addr = 4'd1;
        @(negedge clk);
        chk(bus_rdata, 32'hFFFF_FFFF, "R9", "dir reset");
        chk(pin_oe, 32'h0, "R9", "pin_oe reset");
        chk({31'b0, irq}, 32'h0, "R9", "irq reset");
        step(1);
        rst_n = 1'b1;
        bus_addr = 4'd5;
        @(negedge clk);
        chk(bus_rdata, 32'h0, "R9", "pend reset");
        step(1);

        // Outputs and blinking: high half outputs, some blinking
        wr(4'd1, 32'h0000_FFFF);
        wr(4'd0, 32'hA5A5_0000);
        wr(4'd2, 32'h0F00_000F);
        wr(4'd8, 32'd3);
        bus_addr = 4'd8;
        step(20);
        wr(4'd8, 32'd0);
        step(6);
        wr(4'd4, 32'hDEAD_BEEF);      // R8: level index write ignored
        bus_addr = 4'd4;
        @(negedge clk);
        chk(bus_rdata, 32'h0, "R8", "level after write");
        step(1);

        // Inputs: inversion and level interrupt
        wr(4'd3, 32'h0000_00F0);
        wr(4'd7, 32'h0000_0F00);
        wr(4'd6, 32'h0000_000F);
        bus_addr = 4'd4;
        pin_in = 32'h0000_0100;
        step(1);
        @(negedge clk);
        chk({31'b0, irq}, 32'h0, "R6", "level irq not yet");
        step(1);
        @(negedge clk);
        chk({31'b0, irq}, 32'h1, "R6", "level irq after two edges");
        chk(bus_rdata, 32'h0000_01F0, "R2", "corrected level");
        pin_in = 32'h0;
        step(4);

        // Edge latch and clear-versus-new-edge priority
        wr(4'd5, 32'h0);
        bus_addr = 4'd5;
        pin_in = 32'h0000_0001;
        step(2);
        wr(4'd5, 32'h0);            // clear lands with the new edge
        @(negedge clk);
        chk(bus_rdata, 32'h0000_0001, "R5", "edge wins over clear");
        chk({31'b0, irq}, 32'h1, "R6", "edge irq");
        step(1);
        wr(4'd5, 32'hFFFF_FFFE);
        @(negedge clk);
        chk(bus_rdata, 32'h0, "R5", "cleared by zero bit");
        step(1);

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 4) == 0) pin_in = pin_in ^ (32'h1 << ($urandom % 32));
            if (($urandom % 5) == 0) begin
                logic [3:0]  a;
                logic [31:0] d;
                a = 4'($urandom % 10);
                d = $urandom;
                if (a == 4'd8) d = d % 6;
                wr(a, d);
            end else begin
                bus_addr = 4'($urandom % 10);
                step(1);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule